// File: doc/BRIEF.md
# Clock Mode Switch Controller

This block holds the processor's clock-mode selection and decides which requested changes are allowed. Software writes a two-bit mode select, a multiplier enable bit and a 2x/4x select bit. The controller accepts a mode write only when the transition is legal and otherwise leaves the field as it was. Moving between the multiplier, power management and divide-by-4 modes always goes through divide-by-4. Entry into the multiplier mode also needs a complete, ordered enable handshake and a finished warm-up.

The warm-up is a counter that advances on crystal-cycle strobes once the multiplier enable is set. When it reaches the configured count it raises the ready flag. An accepted mode write updates the select register at once. The active mode output, which drives the clock muxing, takes the new value on the first machine-cycle boundary after the write. The clock generator and the muxing cells are outside this block.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the select reads 10 (divide-by-4), the active mode reads 10, and the multiplier enable, the 2x/4x select and the ready flag all read 0.
- R2: A select write of 01 (reserved) is never accepted, and the select field keeps its value.
- R3: A write of 10 is accepted from any mode. A write of 11 (power management) is accepted only while the select is 10. A direct change between 00 and 11 is rejected and the field is unchanged.
- R4: A write of 00 (multiplier) is accepted only while the select is 10, the ring-mode input is 0, the enable handshake is complete and ready is 1.
- R5: The handshake steps, in order, are: a write of 0 to the enable, then a 2x/4x write, then a write of 1 to the enable. An enable write of 1 that does not follow a 2x/4x write made after an enable clear leaves the handshake incomplete.
- R6: Other writes between the handshake steps do not break it. This covers repeated 2x/4x writes while the enable is 0, writes of 10 to the select, and rejected select writes.
- R7: Ready rises after exactly WARM_CYCLES crystal strobes, counted from the cycle after the enable is set. Cycles without a strobe are not counted.
- R8: A write of 0 to the enable clears ready on the next cycle and restarts the warm-up count.
- R9: A 2x/4x write while the enable is 1 cancels the handshake. A later 00 write is then rejected until the steps are done again.
- R10: The active mode takes the select value at the first machine-cycle strobe that comes strictly after the write, and it changes at no other time.
- R11: Leaving the multiplier mode needs only a single write of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mc_tick_i | input | 1 | Machine-cycle boundary strobe |
| xtal_tick_i | input | 1 | Crystal-cycle strobe for the warm-up counter |
| ring_mode_i | input | 1 | Ring-mode status; 1 blocks entry into the multiplier mode |
| sel_wr_i | input | 1 | Write strobe for the mode select |
| sel_data_i | input | 2 | Requested mode: 00 multiplier, 01 reserved, 10 divide-by-4, 11 power management |
| en_wr_i | input | 1 | Write strobe for the multiplier enable |
| en_data_i | input | 1 | New multiplier enable value |
| x4_wr_i | input | 1 | Write strobe for the 2x/4x select |
| x4_data_i | input | 1 | New 2x/4x select value (1 = 4x) |
| sel_o | output | 2 | Current mode select register |
| active_mode_o | output | 2 | Mode applied to the clock path |
| mul_en_o | output | 1 | Multiplier enable bit |
| x4_o | output | 1 | 2x/4x select bit |
| ready_o | output | 1 | Multiplier warm-up complete |

## Verification
A wrong handshake state stays hidden until a 00 write is attempted. At that point it shows as a select that changes when it should not, or stays at 10 when it should change, one cycle after the write. A bad warm-up count shows on ready_o on the first strobe where the count goes wrong. A bad select shows on sel_o in the cycle after the write, and on active_mode_o at most one machine cycle after that. The reference model in the bench therefore compares all five outputs on every clock. It does this instead of only at the end of each scenario, so every divergence is caught in the cycle where it first appears.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [1:0] {
    SEL_MULT = 2'b00,
    SEL_RSVD = 2'b01,
    SEL_DIV4 = 2'b10,
    SEL_PMM  = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_CLEARED = 2'd1,
    SEQ_CHOSEN  = 2'd2,
    SEQ_WARMING = 2'd3
  } seq_st_e;

  // Legal-transition rule for a select write.
  function automatic logic sel_write_ok(input clk_sel_e cur, input clk_sel_e tgt,
                                        input logic mult_ok);
    logic ok;
    case (tgt)
      SEL_DIV4: ok = 1'b1;
      SEL_PMM:  ok = (cur == SEL_DIV4);
      SEL_MULT: ok = (cur == SEL_DIV4) && mult_ok;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Next handshake state for an enable write.
  function automatic seq_st_e seq_on_enable(input seq_st_e st, input logic val);
    if (!val) return SEQ_CLEARED;
    return (st == SEQ_CHOSEN) ? SEQ_WARMING : SEQ_IDLE;
  endfunction

  // Next handshake state for a 2x/4x write.
  function automatic seq_st_e seq_on_ratio(input seq_st_e st, input logic en_now);
    if (en_now) return SEQ_IDLE;
    if (st == SEQ_CLEARED || st == SEQ_CHOSEN) return SEQ_CHOSEN;
    return st;
  endfunction

endpackage

// File: rtl/clk_mode_warmup.sv
module clk_mode_warmup #(
  parameter int unsigned WARM_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_q_i,
  input  logic restart_i,
  input  logic xtal_tick_i,
  output logic ready_o
);
  localparam int unsigned CW = (WARM_CYCLES > 2) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;
  logic          counting;
  logic          hit_last;

  assign counting = en_q_i && !rdy_q && xtal_tick_i;
  assign hit_last = counting && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (restart_i || !en_q_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (hit_last) begin
      rdy_q <= 1'b1;
    end else if (counting) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;

  assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(restart_i) |-> !rdy_q);

  assert_ready_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> ($past(xtal_tick_i) && $past(cnt_q) == LAST && $past(en_q_i)));

  assert_ready_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !$past(rdy_q)) |-> en_q_i);

endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import clk_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div4_i,
  input  logic en_wr_i,
  input  logic en_data_i,
  input  logic x4_wr_i,
  input  logic x4_data_i,
  output logic mul_en_o,
  output logic x4_o,
  output logic armed_o,
  output logic restart_o
);
  seq_st_e st_q, st_d;
  logic    en_q, x4_q;
  logic    ratio_cancel;

  assign restart_o    = en_wr_i && !en_data_i;
  assign ratio_cancel = x4_wr_i && !en_wr_i && en_q;

  always_comb begin
    st_d = st_q;
    if (!div4_i)      st_d = SEQ_IDLE;
    else if (en_wr_i) st_d = seq_on_enable(st_q, en_data_i);
    else if (x4_wr_i) st_d = seq_on_ratio(st_q, en_q);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q <= SEQ_IDLE;
      en_q <= 1'b0;
      x4_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (en_wr_i) en_q <= en_data_i;
      if (x4_wr_i) x4_q <= x4_data_i;
    end
  end

  assign mul_en_o = en_q;
  assign x4_o     = x4_q;
  assign armed_o  = (st_q == SEQ_WARMING);

  assert_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_WARMING && $past(st_q) != SEQ_WARMING) |->
      ($past(en_wr_i && en_data_i) && $past(st_q) == SEQ_CHOSEN));

  assert_ratio_cancel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ratio_cancel) |-> (st_q == SEQ_IDLE));

  assert_armed_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_WARMING) |-> en_q);

endmodule

// File: rtl/clk_mode_apply.sv
module clk_mode_apply
  import clk_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_wr_i,
  input  logic [1:0] sel_data_i,
  input  logic     mult_ok_i,
  input  logic     mc_tick_i,
  output clk_sel_e sel_o,
  output clk_sel_e act_o,
  output logic     accept_o
);
  clk_sel_e sel_q, act_q, tgt;

  assign tgt      = clk_sel_e'(sel_data_i);
  assign accept_o = sel_wr_i && sel_write_ok(sel_q, tgt, mult_ok_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q <= SEL_DIV4;
      act_q <= SEL_DIV4;
    end else begin
      if (accept_o)  sel_q <= tgt;
      if (mc_tick_i) act_q <= sel_q;
    end
  end

  assign sel_o = sel_q;
  assign act_o = act_q;

  assert_no_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q != SEL_RSVD);

  assert_via_div4_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (sel_q == SEL_DIV4 || $past(sel_q) == SEL_DIV4));

  assert_mult_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_MULT && $past(sel_q) != SEL_MULT) |-> $past(mult_ok_i));

  assert_leave_mult_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && sel_data_i == 2'b10) |=> (sel_q == SEL_DIV4));

  assert_act_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(mc_tick_i) && act_q == $past(sel_q)));

endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mc_tick_i,
  input  logic       xtal_tick_i,
  input  logic       ring_mode_i,
  input  logic       sel_wr_i,
  input  logic [1:0] sel_data_i,
  input  logic       en_wr_i,
  input  logic       en_data_i,
  input  logic       x4_wr_i,
  input  logic       x4_data_i,
  output logic [1:0] sel_o,
  output logic [1:0] active_mode_o,
  output logic       mul_en_o,
  output logic       x4_o,
  output logic       ready_o
);
  clk_sel_e sel_cur, act_cur;
  logic     mul_en, x4, armed, restart, ready, mult_ok, accept;

  clk_mode_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div4_i    (sel_cur == SEL_DIV4),
    .en_wr_i   (en_wr_i),
    .en_data_i (en_data_i),
    .x4_wr_i   (x4_wr_i),
    .x4_data_i (x4_data_i),
    .mul_en_o  (mul_en),
    .x4_o      (x4),
    .armed_o   (armed),
    .restart_o (restart)
  );

  clk_mode_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_q_i      (mul_en),
    .restart_i   (restart),
    .xtal_tick_i (xtal_tick_i),
    .ready_o     (ready)
  );

  assign mult_ok = armed && ready && !ring_mode_i;

  clk_mode_apply u_apply (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_wr_i   (sel_wr_i),
    .sel_data_i (sel_data_i),
    .mult_ok_i  (mult_ok),
    .mc_tick_i  (mc_tick_i),
    .sel_o      (sel_cur),
    .act_o      (act_cur),
    .accept_o   (accept)
  );

  assign sel_o         = sel_cur;
  assign active_mode_o = act_cur;
  assign mul_en_o      = mul_en;
  assign x4_o          = x4;
  assign ready_o       = ready;

  assert_ring_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_cur == SEL_MULT && $past(sel_cur) != SEL_MULT) |->
      (!$past(ring_mode_i) && $past(ready) && $past(accept)));

  assert_reject_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(accept)) |-> (sel_cur == $past(sel_cur)));

endmodule

// File: tb/clk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clk_mode_ctrl_tb;
  localparam int W = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic mc_tick = 0, xtal_tick = 0, ring = 0;
  logic sel_wr = 0, en_wr = 0, en_d = 0, x4_wr = 0, x4_d = 0;
  logic [1:0] sel_d = 2'b00;
  logic [1:0] sel_o, act_o;
  logic en_o, x4_o, rdy_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_sel, m_act, m_en, m_x4, m_rdy, m_cnt, m_step;

  always #2 clk = ~clk;

  clk_mode_ctrl #(.WARM_CYCLES(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mc_tick_i(mc_tick), .xtal_tick_i(xtal_tick),
    .ring_mode_i(ring), .sel_wr_i(sel_wr), .sel_data_i(sel_d),
    .en_wr_i(en_wr), .en_data_i(en_d), .x4_wr_i(x4_wr), .x4_data_i(x4_d),
    .sel_o(sel_o), .active_mode_o(act_o), .mul_en_o(en_o), .x4_o(x4_o), .ready_o(rdy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: steps done counts 0..3, updated from pre-edge values
  always @(posedge clk) begin
    int n_sel, n_act, n_en, n_x4, n_rdy, n_cnt, n_step;
    bit go00;
    if (!rst_n) begin
      m_sel = 2; m_act = 2; m_en = 0; m_x4 = 0; m_rdy = 0; m_cnt = 0; m_step = 0;
    end else begin
      go00 = (m_sel == 2) && !ring && (m_step == 3) && (m_rdy == 1);
      n_sel = m_sel;
      if (sel_wr) begin
        if (sel_d == 2) n_sel = 2;
        else if (sel_d == 3 && m_sel == 2) n_sel = 3;
        else if (sel_d == 0 && go00) n_sel = 0;
      end
      n_step = m_step;
      if (m_sel != 2) n_step = 0;
      else if (en_wr) n_step = en_d ? ((m_step == 2) ? 3 : 0) : 1;
      else if (x4_wr) n_step = m_en ? 0 : ((m_step >= 1) ? 2 : m_step);
      n_en = en_wr ? en_d : m_en;
      n_x4 = x4_wr ? x4_d : m_x4;
      n_rdy = m_rdy; n_cnt = m_cnt;
      if ((en_wr && !en_d) || !m_en) begin n_rdy = 0; n_cnt = 0; end
      else if (!m_rdy && xtal_tick) begin
        if (m_cnt == W - 1) n_rdy = 1; else n_cnt = m_cnt + 1;
      end
      n_act = mc_tick ? m_sel : m_act;
      m_sel = n_sel; m_act = n_act; m_en = n_en; m_x4 = n_x4;
      m_rdy = n_rdy; m_cnt = n_cnt; m_step = n_step;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 select", sel_o, m_sel);
      chk("R10 active mode", act_o, m_act);
      chk("R5 enable", en_o, m_en);
      chk("R5 ratio", x4_o, m_x4);
      chk("R7 ready", rdy_o, m_rdy);
    end
  end

  // free-running strobes
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mc_tick   = (cyc % 4) == 0;
      xtal_tick = (cyc % 3) != 0;
    end
  end

  task automatic w_sel(input logic [1:0] v);
    @(negedge clk); sel_wr = 1; sel_d = v; @(negedge clk); sel_wr = 0;
  endtask
  task automatic w_en(input logic v);
    @(negedge clk); en_wr = 1; en_d = v; @(negedge clk); en_wr = 0;
  endtask
  task automatic w_x4(input logic v);
    @(negedge clk); x4_wr = 1; x4_d = v; @(negedge clk); x4_wr = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_ready(output int cycles);
    cycles = 0;
    while (!rdy_o && cycles < 1000) begin @(negedge clk); cycles++; end
  endtask

  initial begin
    int c;
    idle(4);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 select", sel_o, 2); chk("R1 active", act_o, 2);
    chk("R1 enable", en_o, 0); chk("R1 ratio", x4_o, 0); chk("R1 ready", rdy_o, 0);
    // R2 reserved
    w_sel(2'b01); chk("R2 reserved rejected", sel_o, 2);
    // R3 transitions
    w_sel(2'b11); chk("R3 10->11 accepted", sel_o, 3);
    w_sel(2'b00); chk("R3 11->00 rejected", sel_o, 3);
    w_sel(2'b01); chk("R2 reserved from 11", sel_o, 3);
    w_sel(2'b10); chk("R3 11->10 accepted", sel_o, 2);
    // R4 without handshake
    w_sel(2'b00); chk("R4 00 without handshake", sel_o, 2);
    // full handshake with unrelated writes (R6)
    w_en(0); w_x4(0); w_sel(2'b10); w_x4(1); w_sel(2'b01);
    w_en(1);
    chk("R7 ready low right after enable", rdy_o, 0);
    wait_ready(c);
    chk("R7 warm-up not early", (c >= W) ? 1 : 0, 1);
    ring = 1; w_sel(2'b00); chk("R4 ring mode blocks 00", sel_o, 2);
    ring = 0; w_sel(2'b00); chk("R6 handshake survives extra writes", sel_o, 0);
    idle(6); chk("R10 active follows", act_o, 0);
    w_sel(2'b11); chk("R3 00->11 rejected", sel_o, 0);
    w_sel(2'b10); chk("R11 leave multiplier", sel_o, 2);
    // R8 clear drops ready
    chk("R8 ready still high", rdy_o, 1);
    w_en(0); chk("R8 ready cleared", rdy_o, 0);
    // R5 deviation: set enable without ratio step
    w_en(1); wait_ready(c);
    w_sel(2'b00); chk("R5 out-of-order rejected", sel_o, 2);
    // R9 ratio change while enabled
    w_en(0); w_x4(0); w_en(1); idle(10);
    w_en(0); chk("R8 restart mid warm-up", rdy_o, 0);
    w_x4(1); w_en(1); wait_ready(c);
    w_x4(0); w_sel(2'b00); chk("R9 ratio change cancels", sel_o, 2);
    w_en(0); w_x4(1); w_en(1); wait_ready(c);
    w_sel(2'b00); chk("R9 redo accepted", sel_o, 0);
    idle(6); chk("R10 active mode multiplier", act_o, 0);
    w_sel(2'b10); idle(6); chk("R11 active back to div4", act_o, 2);
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule